// File: doc/BRIEF.md
# PCI Scatter-Gather Address Translator

This block turns an address arriving from the PCI side into a 34-bit system memory address. It does this by looking up a page table that lives in system memory. On a start strobe it takes the PCI address, the window size mask and the table base register. From these it builds the byte address of the one 64-bit table entry that covers the PCI page. It then issues a single read for that entry on a request/response memory port.

When the entry comes back, the block checks its format and its valid bit. It then reports either a physical address or exactly one error flag, together with a one-cycle completion pulse.

The table covers the whole target window at one 8KB page per entry. Its size therefore scales with the window. The mask says how many PCI page-number bits index the table, and how many low bits of the base register give way to them. Only one translation is in flight at any time.

Top module: `sgx_walker`

## Requirements
- R1: After reset, `busy_o`, `req_valid_o`, `done_o` and all three error outputs are 0, and `phys_addr_o` is 0.
- R2: For a mask whose set bits form a run of n ones starting at mask bit 0 (mask bit 0 stands for PCI address bit 20, n from 0 to 12), the entry read address has the following layout. Bits 2:0 are zero. Bits 10+n-1 down to 3 equal PCI address bits 19+n down to 13. Bits 33 down to 10+n equal base register bits 23 down to n (base bit 0 stands for address bit 10).
- R3: `req_valid_o` rises in the cycle after an accepted start. It stays high with `req_addr_o` unchanged until a cycle in which `req_ready_i` is high, and then drops. Exactly one request is made per translation.
- R4: If the returned entry has bit 0 set and bits 63:22 all zero, `done_o` pulses in the cycle after `rsp_valid_i` and no error output is set. `phys_addr_o` equals entry bits 21:1 in address bits 33:13, followed by PCI address bits 12:5 in bits 12:5, with bits 4:0 zero.
- R5: If entry bits 63:22 are zero and entry bit 0 is clear, `err_invalid_o` is high with `done_o` and `phys_addr_o` is 0.
- R6: If any of entry bits 63:22 is set, `err_format_o` is high with `done_o` and `phys_addr_o` is 0. This holds whatever the valid bit is, and `err_invalid_o` stays low. At most one error output is high at a time.
- R7: A mask that is not a run of ones from bit 0 (for example 12'h002) produces `done_o` and `err_config_o` in the cycle after start, with `phys_addr_o` 0 and no memory request.
- R8: `done_o` is a single-cycle pulse, and the error outputs are high only while `done_o` is high. `busy_o` is high from the cycle after an accepted start until the cycle before `done_o`.
- R9: A start while `busy_o` is high has no effect. The result is computed from the inputs captured at the accepted start, and `start_i` and the address inputs need not be held after that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a translation (taken only when idle) |
| pci_addr_i | input | 32 | Incoming PCI target address |
| win_mask_i | input | 12 | Window size mask, bit 0 = PCI address bit 20 |
| tbase_i | input | 24 | Table base register, bit 0 = memory address bit 10 |
| req_valid_o | output | 1 | Entry read request valid |
| req_addr_o | output | 34 | Quadword-aligned byte address of the entry |
| req_ready_i | input | 1 | Memory accepts the request |
| rsp_valid_i | input | 1 | Read data valid |
| rsp_data_i | input | 64 | Returned table entry |
| busy_o | output | 1 | Translation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| phys_addr_o | output | 34 | Translated memory address |
| err_invalid_o | output | 1 | Entry valid bit clear |
| err_format_o | output | 1 | Entry has nonzero must-be-zero bits |
| err_config_o | output | 1 | Mask is not a contiguous run of ones |

## Verification
The hardest situation to reach from the ports is a second start arriving while a read is still outstanding. Here it must be shown that neither the outstanding request address nor the final result picks up the new inputs.

The stimulus raises `start_i` with fresh random address, mask and base values on every cycle of randomly long request-stall and response-wait periods. It scrambles those inputs right after each accepted start. Directed cases cover the narrowest and widest windows, entries with only the top or only the lowest must-be-zero bit set, and entries that are both malformed and marked invalid.

// File: rtl/sgx_pkg.sv
package sgx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } walk_st_e;

   typedef struct packed {
      logic invalid;
      logic fmt;
      logic cfg;
   } sgx_err_t;

endpackage

// File: rtl/sgx_mask_dec.sv
module sgx_mask_dec #(
   parameter int MASK_W = 12,
   localparam int CNT_W = $clog2(MASK_W + 1)
) (
   input  logic [MASK_W-1:0] mask_i,
   output logic [CNT_W-1:0]  run_len_o,
   output logic              contig_o
);

   if (MASK_W < 1) begin : g_bad_w
      $error("sgx_mask_dec: MASK_W must be at least 1");
   end

   // run[i] is set while every mask bit from 0 up to i is set
   logic [MASK_W-1:0] run;

   for (genvar i = 0; i < MASK_W; i++) begin : g_run
      if (i == 0) begin : g_first
         assign run[i] = mask_i[0];
      end else begin : g_next
         assign run[i] = run[i-1] & mask_i[i];
      end
   end

   always_comb begin
      run_len_o = '0;
      for (int i = 0; i < MASK_W; i++) begin
         run_len_o = run_len_o + CNT_W'(run[i]);
      end
   end

   // a legal mask is exactly its own leading run
   assign contig_o = (run == mask_i);

endmodule

// File: rtl/sgx_pte_addr.sv
module sgx_pte_addr #(
   parameter int PA_W       = 34,
   parameter int PCI_W      = 32,
   parameter int PAGE_SH    = 13,
   parameter int MIN_TBL_SH = 10,
   parameter int MASK_W     = 12,
   localparam int CNT_W     = $clog2(MASK_W + 1),
   localparam int BASE_W    = PA_W - MIN_TBL_SH,
   localparam int PGN_W     = PCI_W - PAGE_SH
) (
   input  logic [BASE_W-1:0] tbase_i,
   input  logic [PGN_W-1:0]  pci_pgn_i,
   input  logic [CNT_W-1:0]  run_len_i,
   output logic [PA_W-1:0]   qaddr_o
);

   if (MIN_TBL_SH + MASK_W > PA_W) begin : g_bad_base
      $error("sgx_pte_addr: largest table exceeds the address width");
   end
   if (MIN_TBL_SH + MASK_W - 3 > PGN_W) begin : g_bad_pci
      $error("sgx_pte_addr: PCI page number too narrow for the largest table");
   end
   if (MIN_TBL_SH < 3) begin : g_bad_min
      $error("sgx_pte_addr: smallest table must hold at least one entry");
   end

   logic [PA_W-1:0] base_full;
   logic [PA_W-1:0] idx_full;
   logic [PA_W-1:0] hi_keep;

   assign base_full = {tbase_i, {MIN_TBL_SH{1'b0}}};
   // page number scaled by the 8-byte entry size
   assign idx_full  = PA_W'(pci_pgn_i) << 3;
   // ones above the table size, zeros inside it
   assign hi_keep   = {PA_W{1'b1}} << (MIN_TBL_SH + int'(run_len_i));
   assign qaddr_o   = (base_full & hi_keep) | (idx_full & ~hi_keep);

endmodule

// File: rtl/sgx_pte_check.sv
module sgx_pte_check #(
   parameter int PTE_W    = 64,
   parameter int PA_W     = 34,
   parameter int PAGE_SH  = 13,
   parameter int LINE_SH  = 5,
   localparam int PG_W    = PA_W - PAGE_SH,
   localparam int LINE_W  = PAGE_SH - LINE_SH
) (
   input  logic [PTE_W-1:0]  pte_i,
   input  logic [LINE_W-1:0] line_i,
   output logic [PA_W-1:0]   phys_o,
   output logic              invalid_o,
   output logic              fmt_o
);

   if (PG_W + 1 > PTE_W) begin : g_bad_pte
      $error("sgx_pte_check: entry too narrow for the page number");
   end
   if (LINE_SH < 1 || LINE_SH >= PAGE_SH) begin : g_bad_line
      $error("sgx_pte_check: line shift must lie inside the page");
   end

   logic mbz_set;

   if (PTE_W > PG_W + 1) begin : g_mbz
      assign mbz_set = |pte_i[PTE_W-1:PG_W+1];
   end else begin : g_no_mbz
      assign mbz_set = 1'b0;
   end

   assign fmt_o     = mbz_set;
   assign invalid_o = ~mbz_set & ~pte_i[0];
   assign phys_o    = {pte_i[PG_W:1], line_i, {LINE_SH{1'b0}}};

endmodule

// File: rtl/sgx_walker.sv
module sgx_walker #(
   parameter int PA_W       = 34,
   parameter int PCI_W      = 32,
   parameter int PTE_W      = 64,
   parameter int MASK_W     = 12,
   parameter int PAGE_SH    = 13,
   parameter int LINE_SH    = 5,
   parameter int MIN_TBL_SH = 10,
   localparam int BASE_W    = PA_W - MIN_TBL_SH,
   localparam int LINE_W    = PAGE_SH - LINE_SH,
   localparam int CNT_W     = $clog2(MASK_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [PCI_W-1:0]  pci_addr_i,
   input  logic [MASK_W-1:0] win_mask_i,
   input  logic [BASE_W-1:0] tbase_i,
   output logic              req_valid_o,
   output logic [PA_W-1:0]   req_addr_o,
   input  logic              req_ready_i,
   input  logic              rsp_valid_i,
   input  logic [PTE_W-1:0]  rsp_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [PA_W-1:0]   phys_addr_o,
   output logic              err_invalid_o,
   output logic              err_format_o,
   output logic              err_config_o
);
   import sgx_pkg::*;

   if (PAGE_SH >= PCI_W || PAGE_SH >= PA_W) begin : g_bad_page
      $error("sgx_walker: page shift out of range");
   end

   logic [CNT_W-1:0]  run_len;
   logic              contig;
   logic [PA_W-1:0]   qaddr_live;
   logic [PA_W-1:0]   phys_live;
   logic              inv_live;
   logic              fmt_live;

   walk_st_e          state;
   logic [PA_W-1:0]   qaddr_q;
   logic [LINE_W-1:0] line_q;
   logic              done_q;
   logic [PA_W-1:0]   phys_q;
   sgx_err_t          err_q;

   logic unused_low_bits;
   assign unused_low_bits = ^pci_addr_i[LINE_SH-1:0];

   sgx_mask_dec #(.MASK_W(MASK_W)) u_mask (
      .mask_i    (win_mask_i),
      .run_len_o (run_len),
      .contig_o  (contig)
   );

   sgx_pte_addr #(
      .PA_W(PA_W), .PCI_W(PCI_W), .PAGE_SH(PAGE_SH),
      .MIN_TBL_SH(MIN_TBL_SH), .MASK_W(MASK_W)
   ) u_addr (
      .tbase_i   (tbase_i),
      .pci_pgn_i (pci_addr_i[PCI_W-1:PAGE_SH]),
      .run_len_i (run_len),
      .qaddr_o   (qaddr_live)
   );

   sgx_pte_check #(
      .PTE_W(PTE_W), .PA_W(PA_W), .PAGE_SH(PAGE_SH), .LINE_SH(LINE_SH)
   ) u_check (
      .pte_i     (rsp_data_i),
      .line_i    (line_q),
      .phys_o    (phys_live),
      .invalid_o (inv_live),
      .fmt_o     (fmt_live)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         qaddr_q <= '0;
         line_q  <= '0;
         done_q  <= 1'b0;
         phys_q  <= '0;
         err_q   <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start_i) begin
                  err_q  <= '0;
                  phys_q <= '0;
                  if (!contig) begin
                     done_q    <= 1'b1;
                     err_q.cfg <= 1'b1;
                  end else begin
                     state   <= ST_REQ;
                     qaddr_q <= qaddr_live;
                     line_q  <= pci_addr_i[PAGE_SH-1:LINE_SH];
                  end
               end
            end
            ST_REQ: begin
               if (req_ready_i) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rsp_valid_i) begin
                  state         <= ST_IDLE;
                  done_q        <= 1'b1;
                  err_q.invalid <= inv_live;
                  err_q.fmt     <= fmt_live;
                  phys_q        <= (inv_live | fmt_live) ? '0 : phys_live;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_valid_o   = (state == ST_REQ);
   assign req_addr_o    = qaddr_q;
   assign busy_o        = (state != ST_IDLE);
   assign done_o        = done_q;
   assign phys_addr_o   = phys_q;
   assign err_invalid_o = done_q & err_q.invalid;
   assign err_format_o  = done_q & err_q.fmt;
   assign err_config_o  = done_q & err_q.cfg;

   // R3: a stalled request keeps its address
   a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));

   // R2: entry reads are quadword aligned
   a_r2_qw_align: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> req_addr_o[2:0] == 3'b000);

   // R8: completion is a single-cycle pulse
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6: never more than one error reported
   a_r6_err_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $countones({err_invalid_o, err_format_o, err_config_o}) <= 1);

   // R5: a failed translation presents no address
   a_r5_err_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && (err_invalid_o || err_format_o || err_config_o) |-> phys_addr_o == '0);

   // R7: a configuration error never reaches the memory port
   a_r7_cfg_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      err_config_o |-> !req_valid_o && !busy_o);

   // R9: a start during a walk leaves the entry address alone
   a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i |=> $stable(req_addr_o));

endmodule

// File: tb/sgx_walker_tb.sv
module sgx_walker_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] pci_addr_i = '0;
   logic [11:0] win_mask_i = '0;
   logic [23:0] tbase_i = '0;
   logic        req_valid_o;
   logic [33:0] req_addr_o;
   logic        req_ready_i = 1'b0;
   logic        rsp_valid_i = 1'b0;
   logic [63:0] rsp_data_i = '0;
   logic        busy_o;
   logic        done_o;
   logic [33:0] phys_addr_o;
   logic        err_invalid_o;
   logic        err_format_o;
   logic        err_config_o;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sgx_walker dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .pci_addr_i(pci_addr_i),
      .win_mask_i(win_mask_i), .tbase_i(tbase_i), .req_valid_o(req_valid_o),
      .req_addr_o(req_addr_o), .req_ready_i(req_ready_i), .rsp_valid_i(rsp_valid_i),
      .rsp_data_i(rsp_data_i), .busy_o(busy_o), .done_o(done_o),
      .phys_addr_o(phys_addr_o), .err_invalid_o(err_invalid_o),
      .err_format_o(err_format_o), .err_config_o(err_config_o)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit is_contig(input logic [11:0] m);
      bit seen_zero = 1'b0;
      for (int i = 0; i < 12; i++) begin
         if (!m[i]) seen_zero = 1'b1;
         else if (seen_zero) return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic logic [33:0] exp_qaddr(input logic [11:0] m, input logic [31:0] ad,
                                             input logic [23:0] b);
      int n = 0;
      logic [33:0] r = '0;
      for (int i = 0; i < 12; i++) if (m[i]) n++;
      for (int i = 3; i < 34; i++) begin
         if (i < 10 + n) r[i] = ad[i + 10];
         else            r[i] = b[i - 10];
      end
      return r;
   endfunction

   function automatic logic [33:0] exp_phys(input logic [63:0] e, input logic [31:0] ad);
      logic [33:0] r = '0;
      for (int i = 5; i < 13; i++) r[i] = ad[i];
      for (int i = 13; i < 34; i++) r[i] = e[i - 12];
      return r;
   endfunction

   task automatic scramble();
      pci_addr_i = $urandom;
      win_mask_i = 12'($urandom);
      tbase_i    = 24'($urandom);
   endtask

   task automatic run_one(input logic [11:0] m, input logic [31:0] ad, input logic [23:0] b,
                          input logic [63:0] e, input int rdy_dly, input int rsp_dly,
                          input bit poke);
      logic [33:0] qa;
      bit fmt, inv;
      qa  = exp_qaddr(m, ad, b);
      fmt = |e[63:22];
      inv = !fmt && !e[0];
      @(negedge clk);
      start_i = 1'b1; pci_addr_i = ad; win_mask_i = m; tbase_i = b;
      @(negedge clk);
      start_i = 1'b0;
      scramble();
      if (!is_contig(m)) begin
         check(done_o && err_config_o && !req_valid_o, "R7 config error",
               {61'd0, done_o, err_config_o, req_valid_o}, 64'h6);
         check(phys_addr_o == '0 && !busy_o, "R7 no address",
               64'(phys_addr_o), 64'h0);
         @(negedge clk);
         check(!done_o && !err_config_o, "R8 pulse ends",
               {62'd0, done_o, err_config_o}, 64'h0);
         return;
      end
      check(busy_o && req_valid_o, "R8 busy after start",
            {62'd0, busy_o, req_valid_o}, 64'h3);
      check(req_addr_o == qa, "R2 entry address", 64'(req_addr_o), 64'(qa));
      for (int k = 0; k < rdy_dly; k++) begin
         start_i = poke;
         if (poke) scramble();
         @(negedge clk);
         check(req_valid_o && req_addr_o == qa, "R3 request held",
               64'(req_addr_o), 64'(qa));
      end
      start_i = 1'b0;
      req_ready_i = 1'b1;
      @(negedge clk);
      req_ready_i = 1'b0;
      check(!req_valid_o && busy_o, "R3 single request",
            {62'd0, req_valid_o, busy_o}, 64'h1);
      for (int k = 0; k < rsp_dly; k++) begin
         start_i = poke;
         if (poke) scramble();
         @(negedge clk);
         check(!done_o && busy_o && !req_valid_o, "R9 busy ignores start",
               {61'd0, done_o, busy_o, req_valid_o}, 64'h2);
      end
      start_i = 1'b0;
      rsp_valid_i = 1'b1;
      rsp_data_i  = e;
      @(negedge clk);
      rsp_valid_i = 1'b0;
      rsp_data_i  = {$urandom, $urandom};
      check(done_o && !busy_o, "R8 done after response", {62'd0, done_o, busy_o}, 64'h2);
      check(err_format_o == fmt, "R6 format flag", 64'(err_format_o), 64'(fmt));
      check(err_invalid_o == inv, "R5 invalid flag", 64'(err_invalid_o), 64'(inv));
      check(!err_config_o, "R4 no config error", 64'(err_config_o), 64'h0);
      if (fmt || inv)
         check(phys_addr_o == '0, "R5 R6 no address on error", 64'(phys_addr_o), 64'h0);
      else
         check(phys_addr_o == exp_phys(e, ad), "R4 R9 physical address",
               64'(phys_addr_o), 64'(exp_phys(e, ad)));
      @(negedge clk);
      check(!done_o && !err_format_o && !err_invalid_o, "R8 pulse ends",
            {61'd0, done_o, err_format_o, err_invalid_o}, 64'h0);
   endtask

   function automatic logic [63:0] rand_pte();
      logic [63:0] e;
      int kind = int'($urandom_range(0, 9));
      e = {42'd0, 21'($urandom), 1'b1};
      if (kind == 7) e[0] = 1'b0;
      if (kind == 8) e[22 + $urandom_range(0, 41)] = 1'b1;
      if (kind == 9) begin
         e[0] = 1'b0;
         e[63:22] = 42'({$urandom, $urandom});
         e[22] = 1'b1;
      end
      return e;
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy_o && !req_valid_o && !done_o, "R1 reset idle",
            {61'd0, busy_o, req_valid_o, done_o}, 64'h0);
      check(!err_invalid_o && !err_format_o && !err_config_o && phys_addr_o == '0,
            "R1 reset outputs", 64'(phys_addr_o), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !done_o, "R1 idle after release", {62'd0, busy_o, done_o}, 64'h0);

      // directed corners
      run_one(12'h000, 32'hFFFF_FFFF, 24'hFF_FFFF, 64'h0000_0000_003F_FFFF, 0, 0, 1'b0);
      run_one(12'hFFF, 32'hFFFF_FFFF, 24'hFF_FFFF, 64'h0000_0000_0000_0003, 2, 1, 1'b1);
      run_one(12'h00F, 32'h00AB_CDE0, 24'h12_3456, 64'h8000_0000_0000_0001, 1, 2, 1'b0);
      run_one(12'h001, 32'h1234_5678, 24'hA5_A5A5, 64'h0000_0000_0040_0001, 0, 3, 1'b1);
      run_one(12'h03F, 32'h8765_4321, 24'h00_0001, 64'h0000_0000_0000_0000, 3, 0, 1'b0);
      run_one(12'h07F, 32'h0F0F_0F0F, 24'h5A_5A5A, 64'hFFFF_FFFF_FFC0_0000, 1, 1, 1'b1);
      run_one(12'h002, 32'h1111_1111, 24'h22_2222, 64'h1, 0, 0, 1'b0);
      run_one(12'h800, 32'h3333_3333, 24'h44_4444, 64'h1, 0, 0, 1'b0);
      run_one(12'h0F7, 32'h5555_5555, 24'h66_6666, 64'h1, 0, 0, 1'b0);

      // constrained random
      for (int t = 0; t < 300; t++) begin
         logic [11:0] m;
         if ($urandom_range(0, 7) == 0) m = 12'($urandom);
         else m = 12'((1 << $urandom_range(0, 12)) - 1);
         run_one(m, $urandom, 24'($urandom), rand_pte(),
                 int'($urandom_range(0, 4)), int'($urandom_range(0, 5)),
                 1'($urandom_range(0, 1)));
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule